// File: doc/BRIEF.md
# Start-Triggered Run Counter with Two Flags

This block is a small three-state sequencer. It drives a 4-bit counter and two single-bit flags. While the sequencer is idle, it waits for a start request. When the request arrives, it clears the counter and the finish flag, then enters a counting phase. In that phase the counter advances once per clock. The flag `flagE` follows bit 2 of the counter value seen at each counting edge.

The run ends when the counter's two upper bits are both 1. At that edge the sequencer moves into a one-cycle finish state. The finish state raises `flagF` and returns the sequencer to idle. The counter, both flags and the encoded state are visible at the ports, so a neighbour can follow the whole run.

Top module: `startCountSequencer`

## Requirements
- R1: While `rstN` is low, the outputs are `state` = 2'b00 (idle), `count` = 0, `flagE` = 0 and `flagF` = 0.
- R2: In idle with `start` = 1, the next edge sets `count` to 0, clears `flagF`, moves `state` to 2'b01 (counting) and leaves `flagE` unchanged.
- R3: In idle with `start` = 0, the next edge leaves `state`, `count`, `flagE` and `flagF` unchanged.
- R4: In counting, every edge increments `count` by one, modulo 16.
- R5: In counting, every edge loads `flagE` with bit 2 of the `count` value present before that edge.
- R6: In counting, when bits 3 and 2 of `count` are both 1, the edge moves `state` to 2'b11 (finish). Otherwise the sequencer stays in counting. `start` has no effect while counting.
- R7: In finish, the next edge sets `flagF` to 1, returns `state` to 2'b00 and holds `count` and `flagE`.
- R8: A run launched from idle spends exactly 13 clocks in counting and leaves `count` = 13 when it returns to idle.
- R9: `state` uses the codes 00 (idle), 01 (counting) and 11 (finish). The code 10 never appears, and if it is ever held, it leads to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled in idle only |
| count | output | 4 | Run counter value |
| flagE | output | 1 | Copy of count bit 2 taken at each counting edge |
| flagF | output | 1 | Set by the finish state, cleared by a new launch |
| state | output | 2 | Encoded sequencer state |

## Verification
The hardest cases to reach are the ones that depend on history. One is a relaunch from an already finished run, where `flagE` must keep its value 1 while `flagF` drops. The other is the exit edge at count 12, where `flagE` rises on the same edge that leaves counting. The stimulus therefore runs one full run through a vector table. It then launches a second run straight from the finished state with `start` held high through counting, and counts the cycles spent there. A final launch is cut off by reset in the middle of the run.

// File: rtl/seqPkg.sv
package seqPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_COUNT = 2'b01,
    ST_DONE  = 2'b11
  } seqState_e;

  typedef struct packed {
    logic clearRun;
    logic bumpCount;
    logic trackE;
    logic raiseF;
  } strobe_t;

endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      stopHit,
  output seqState_e curState,
  output strobe_t   cmd
);

  seqState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  always_comb begin
    cmd       = '0;
    nextState = ST_IDLE;
    case (curState)
      ST_IDLE: begin
        if (start) begin
          cmd.clearRun = 1'b1;
          nextState    = ST_COUNT;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_COUNT: begin
        cmd.bumpCount = 1'b1;
        cmd.trackE    = 1'b1;
        nextState     = stopHit ? ST_DONE : ST_COUNT;
      end
      ST_DONE: begin
        cmd.raiseF = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE; // unused code 10 recovers to idle (R9)
    endcase
  end

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          cmd,
  output logic [WIDTH-1:0] count,
  output logic             flagE,
  output logic             flagF,
  output logic             stopHit
);

  localparam int TOP_BIT = WIDTH - 1;
  localparam int SUB_BIT = WIDTH - 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (cmd.clearRun)  count <= '0;
    else if (cmd.bumpCount) count <= count + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           flagE <= 1'b0;
    else if (cmd.trackE) flagE <= count[SUB_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagF <= 1'b0;
    else if (cmd.clearRun) flagF <= 1'b0;
    else if (cmd.raiseF)   flagF <= 1'b1;
  end

  assign stopHit = count[TOP_BIT] & count[SUB_BIT];

endmodule

// File: rtl/startCountSequencer.sv
module startCountSequencer
  import seqPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic [WIDTH-1:0] count,
  output logic             flagE,
  output logic             flagF,
  output logic [1:0]       state
);

  seqState_e curState;
  strobe_t   cmd;
  logic      stopHit;

  seqControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stopHit  (stopHit),
    .curState (curState),
    .cmd      (cmd)
  );

  seqDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .count   (count),
    .flagE   (flagE),
    .flagF   (flagF),
    .stopHit (stopHit)
  );

  assign state = curState;

endmodule

// File: rtl/seqChecker.sv
module seqChecker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] count,
  input logic             flagE,
  input logic             flagF,
  input logic [1:0]       state
);

  localparam logic [1:0] S_IDLE  = 2'b00;
  localparam logic [1:0] S_COUNT = 2'b01;
  localparam logic [1:0] S_DONE  = 2'b11;
  localparam int TOP_BIT = WIDTH - 1;
  localparam int SUB_BIT = WIDTH - 2;

  a_r2_launch_clears: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start) |=> (state == S_COUNT && count == '0 && !flagF && flagE == $past(flagE)));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !start) |=> (state == S_IDLE && $stable(count) && $stable(flagE) && $stable(flagF)));

  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COUNT) |=> (count == $past(count) + WIDTH'(1)));

  a_r5_e_follows_bit: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COUNT) |=> (flagE == $past(count[SUB_BIT])));

  a_r6_exit_on_top: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COUNT && count[TOP_BIT] && count[SUB_BIT]) |=> (state == S_DONE));

  a_r6_stay_counting: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COUNT && !(count[TOP_BIT] && count[SUB_BIT])) |=> (state == S_COUNT));

  a_r7_finish_sets_f: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |=> (state == S_IDLE && flagF && $stable(count) && $stable(flagE)));

  a_r9_no_unused_code: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b10);

endmodule

bind startCountSequencer seqChecker #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .count (count),
  .flagE (flagE),
  .flagF (flagF),
  .state (state)
);

// File: tb/startCountSequencer_tb.sv
module startCountSequencer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] count;
  logic       flagE;
  logic       flagF;
  logic [1:0] state;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  startCountSequencer u_dut (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .count (count),
    .flagE (flagE),
    .flagF (flagF),
    .state (state)
  );

  // vector: start driven, then expected {state, count, flagE, flagF} after the edge
  typedef struct packed {
    logic       stim;
    logic [1:0] expState;
    logic [3:0] expCount;
    logic       expE;
    logic       expF;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'b01, 4'd0,  1'b0, 1'b0}, // launch
    '{1'b0, 2'b01, 4'd1,  1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd2,  1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd3,  1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd4,  1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd5,  1'b1, 1'b0},
    '{1'b0, 2'b01, 4'd6,  1'b1, 1'b0},
    '{1'b0, 2'b01, 4'd7,  1'b1, 1'b0},
    '{1'b0, 2'b01, 4'd8,  1'b1, 1'b0},
    '{1'b0, 2'b01, 4'd9,  1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd10, 1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd11, 1'b0, 1'b0},
    '{1'b0, 2'b01, 4'd12, 1'b0, 1'b0},
    '{1'b0, 2'b11, 4'd13, 1'b1, 1'b0}, // exit edge
    '{1'b0, 2'b00, 4'd13, 1'b1, 1'b1}, // finish
    '{1'b0, 2'b00, 4'd13, 1'b1, 1'b1}, // idle hold
    '{1'b0, 2'b00, 4'd13, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {state, count, flagE, flagF};
  endfunction

  task automatic step(input logic s);
    start = s;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int inT1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset values", outs(), 8'h00);
    rstN = 1'b1;
    step(1'b0);
    check("R3 idle without start", outs(), 8'h00);

    // table walk (R2 R4 R5 R6 R7 R3)
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].stim);
      check($sformatf("table row %0d R2 R4 R5 R6 R7", i), outs(),
            {VECS[i].expState, VECS[i].expCount, VECS[i].expE, VECS[i].expF});
      check("R9 unused code", {6'd0, state}, (state == 2'b10) ? 8'h00 : {6'd0, state});
    end

    // relaunch from finished run: E must keep 1, F drops
    step(1'b1);
    check("R2 relaunch keeps flagE", outs(), {2'b01, 4'd0, 1'b1, 1'b0});
    // start held high while counting is ignored
    step(1'b1);
    check("R6 start ignored in counting", outs(), {2'b01, 4'd1, 1'b0, 1'b0});
    inT1 = 2;
    for (int k = 0; k < 20; k++) begin
      step(1'b1);
      if (state != 2'b01) break;
      inT1++;
    end
    check("R8 clocks in counting", 8'(inT1), 8'd13);
    check("R8 exit values", outs(), {2'b11, 4'd13, 1'b1, 1'b0});
    step(1'b0);
    check("R7 finish sets flagF", outs(), {2'b00, 4'd13, 1'b1, 1'b1});

    // reset in the middle of a run
    step(1'b1);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    check("R5 mid run flagE", outs(), {2'b01, 4'd5, 1'b1, 1'b0});
    rstN = 1'b0;
    #2;
    check("R1 async reset mid run", outs(), 8'h00);
    @(posedge clk);
    #1;
    rstN = 1'b1;
    step(1'b0);
    check("R3 idle after reset", outs(), 8'h00);
    finish_run();
  end

endmodule